// File: doc/BRIEF.md
# Ten-Bit LSB-First Serializer with Loopback Routing

This block turns a stream of already-encoded 10-bit words into a serial bit stream. It runs on the bit clock. A one-cycle byte strobe marks every tenth bit-clock edge, and the word present on that edge is taken in. Its bits then leave one per bit clock, lowest bit first, after a fixed pipeline delay of two bit clocks. When words arrive every ten cycles, they follow each other with no gap.

The serial stream is normally copied onto two identical line outputs. In loopback mode both line outputs are held at logic 1, and the stream is sent to an internal wrap output so that a receiver can be tested without the line. When loopback is off, the wrap output rests at 1.

An error pulse is raised whenever a strobe arrives at any spacing other than ten cycles after the previous one. The word taken on that strobe restarts the shifting, and the unsent bits of the old word are dropped.

Top module: `ser_tx_lsb`

## Requirements
- R1: While `word_stb` is high at a rising edge, all ten bits of `word_in` are captured on that edge. No other edge captures a word.
- R2: Bit i (0 = LSB … 9 = MSB) of a word captured at edge e is the serial value shown in the cycle that follows edge e+2+i. The latency is two bit clocks and is the same for every word.
- R3: Words strobed exactly ten edges apart form a continuous stream: bit 9 of one word is followed directly by bit 0 of the next.
- R4: `line_a` and `line_b` always carry the same value.
- R5: With `loop_en` high, both line outputs are 1 and `wrap_out` carries the serial value. With `loop_en` low, `wrap_out` is 1 and the lines carry the serial value.
- R6: During synchronous active-high reset, and after it until bit 0 of the first captured word appears, the serial value is 1 and `err_align` is 0.
- R7: A strobe that comes at a spacing other than ten edges after the previous strobe makes `err_align` high for exactly the cycle after that edge. Its word then starts at bit 0 with the R2 latency, and it replaces whatever was left of the earlier word.
- R8: Once the last bit of a word has been sent and no new word has followed, the serial value is 1.
- R9: A change on `loop_en` reroutes the outputs in the same cycle and does not shift the timing of the serial stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| word_stb | input | 1 | Byte strobe; word boundary marker |
| word_in | input | 10 | Encoded word, bit 0 sent first |
| loop_en | input | 1 | Loopback select |
| line_a | output | 1 | Serial line output A |
| line_b | output | 1 | Serial line output B |
| wrap_out | output | 1 | Internal loopback serial output |
| err_align | output | 1 | One-cycle pulse on an irregular strobe spacing |

## Verification
A fault in the holding or shift register shows up as a wrong serial bit within the ten cycles of the affected word. It starts two cycles after the word is captured. A wrong start flag shows up as a premature 0 or a missing bit 0 right after the first strobe. A strobe-spacing counter that is off by one shows up on the very next strobe: `err_align` fires on a regular spacing or stays quiet on an irregular one. The stream is checked against an expected bit schedule in every cycle, so a slip of even one cycle is caught at once.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  // True when the measured strobe spacing equals one full word.
  function automatic logic gap_is_regular(input int unsigned gap, input int unsigned word_w);
    return gap == word_w;
  endfunction

  // Spacing counter step, saturating one past the word length.
  function automatic int unsigned gap_advance(input int unsigned gap, input int unsigned word_w);
    return (gap > word_w) ? gap : gap + 1;
  endfunction

  // Level driven on a line output.
  function automatic logic line_level(input logic loop, input logic bit_v);
    return loop ? 1'b1 : bit_v;
  endfunction

  // Level driven on the internal wrap output.
  function automatic logic wrap_level(input logic loop, input logic bit_v);
    return loop ? bit_v : 1'b1;
  endfunction

endpackage

// File: rtl/ser_tx_capture.sv
module ser_tx_capture
  import ser_tx_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] hold_word,
  output logic              load_pulse,
  output logic              err_align
);
  localparam int GAP_W = $clog2(WORD_W + 2);

  logic [GAP_W-1:0] gap_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_word  <= '0;
      load_pulse <= 1'b0;
      err_align  <= 1'b0;
      gap_q      <= '0;
      armed_q    <= 1'b0;
    end else begin
      load_pulse <= word_stb;
      err_align  <= word_stb && armed_q &&
                    !gap_is_regular(int'(gap_q), WORD_W);
      if (word_stb) begin
        hold_word <= word_in;
        gap_q     <= GAP_W'(1);
        armed_q   <= 1'b1;
      end else begin
        gap_q <= GAP_W'(gap_advance(int'(gap_q), WORD_W));
      end
    end
  end
endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_pulse,
  input  logic [WORD_W-1:0] hold_word,
  output logic              ser_bit
);
  logic [WORD_W-1:0] sh_q;
  logic              started_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      started_q <= 1'b0;
      ser_bit   <= 1'b1;
    end else begin
      ser_bit <= started_q ? sh_q[0] : 1'b1;
      if (load_pulse) begin
        sh_q      <= hold_word;
        started_q <= 1'b1;
      end else begin
        sh_q <= {1'b1, sh_q[WORD_W-1:1]};
      end
    end
  end
endmodule

// File: rtl/ser_tx_route.sv
module ser_tx_route
  import ser_tx_pkg::*;
#(
  parameter int N_LINE = 2
) (
  input  logic              loop_en,
  input  logic              ser_bit,
  output logic [N_LINE-1:0] lines,
  output logic              wrap_bit
);
  for (genvar g = 0; g < N_LINE; g++) begin : g_line
    assign lines[g] = line_level(loop_en, ser_bit);
  end
  assign wrap_bit = wrap_level(loop_en, ser_bit);
endmodule

// File: rtl/ser_tx_lsb.sv
module ser_tx_lsb #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] word_in,
  input  logic              loop_en,
  output logic              line_a,
  output logic              line_b,
  output logic              wrap_out,
  output logic              err_align
);
  localparam int N_LINE = 2;

  logic [WORD_W-1:0] hold_word;
  logic              load_pulse;
  logic              ser_bit;
  logic [N_LINE-1:0] lines;

  ser_tx_capture #(.WORD_W(WORD_W)) u_cap (
    .clk(clk), .rst(rst), .word_stb(word_stb), .word_in(word_in),
    .hold_word(hold_word), .load_pulse(load_pulse), .err_align(err_align)
  );

  ser_tx_shifter #(.WORD_W(WORD_W)) u_shf (
    .clk(clk), .rst(rst), .load_pulse(load_pulse),
    .hold_word(hold_word), .ser_bit(ser_bit)
  );

  ser_tx_route #(.N_LINE(N_LINE)) u_rte (
    .loop_en(loop_en), .ser_bit(ser_bit), .lines(lines), .wrap_bit(wrap_out)
  );

  assign line_a = lines[0];
  assign line_b = lines[1];
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
  input logic clk,
  input logic rst,
  input logic word_stb,
  input logic loop_en,
  input logic line_a,
  input logic line_b,
  input logic wrap_out,
  input logic err_align,
  input logic load_pulse,
  input logic ser_bit
);
  AST_LOAD_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
    word_stb |=> load_pulse); // R1
  AST_NO_UNPROMPTED_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_pulse |-> $past(word_stb)); // R1
  AST_LINES_TWIN: assert property (@(posedge clk) disable iff (rst)
    line_a == line_b); // R4
  AST_LOOP_PARKS_LINES: assert property (@(posedge clk) disable iff (rst)
    loop_en |-> (line_a && line_b && (wrap_out == ser_bit))); // R5
  AST_WRAP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !loop_en |-> (wrap_out && (line_a == ser_bit))); // R5
  AST_ERR_NEEDS_STB: assert property (@(posedge clk) disable iff (rst)
    err_align |-> $past(word_stb)); // R7
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    err_align |=> !err_align || $past(word_stb)); // R7
endmodule

bind ser_tx_lsb ser_tx_chk u_chk (
  .clk(clk), .rst(rst), .word_stb(word_stb), .loop_en(loop_en),
  .line_a(line_a), .line_b(line_b), .wrap_out(wrap_out),
  .err_align(err_align), .load_pulse(load_pulse), .ser_bit(ser_bit)
);

// File: tb/tb_ser_tx_lsb.sv
module tb_ser_tx_lsb;
  localparam int W = 10;
  localparam int SCHED_N = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic word_stb = 1'b0;
  logic [W-1:0] word_in = '0;
  logic loop_en = 1'b0;
  logic line_a, line_b, wrap_out, err_align;

  int errors = 0;
  int checks = 0;
  int edge_n = 0;
  int last_stb = 0;
  bit have_prev = 0;
  bit exp_err;
  logic sched [SCHED_N];

  always #4 clk = ~clk;

  ser_tx_lsb dut (
    .clk(clk), .rst(rst), .word_stb(word_stb), .word_in(word_in),
    .loop_en(loop_en), .line_a(line_a), .line_b(line_b),
    .wrap_out(wrap_out), .err_align(err_align)
  );

  task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at edge %0d: actual=%b expected=%b", tag, edge_n, act, exp);
    end
  endtask

  function automatic logic exp_line(input logic lp, input logic s);
    if (lp) return 1'b1;
    return s;
  endfunction

  function automatic logic exp_wrap(input logic lp, input logic s);
    if (!lp) return 1'b1;
    return s;
  endfunction

  // One bit-clock step: drive, take the edge, update the schedule, check at the falling edge.
  task automatic step(input bit stb, input logic [W-1:0] w, input bit lp, input string tag);
    word_stb = stb; word_in = w; loop_en = lp;
    @(posedge clk);
    edge_n++;
    exp_err = 1'b0;
    if (stb) begin
      for (int i = 0; i < W; i++) sched[edge_n + 2 + i] = w[i];  // R2 latency
      exp_err = have_prev && (edge_n - last_stb != W);          // R7
      have_prev = 1'b1;
      last_stb = edge_n;
    end
    @(negedge clk);
    chk(line_a === exp_line(lp, sched[edge_n]), tag, line_a, exp_line(lp, sched[edge_n]));
    chk(line_b === line_a, "R4", line_b, line_a);
    chk(wrap_out === exp_wrap(lp, sched[edge_n]), "R5", wrap_out, exp_wrap(lp, sched[edge_n]));
    chk(err_align === exp_err, "R7", err_align, exp_err);
  endtask

  task automatic send(input logic [W-1:0] w, input int gap, input bit lp, input string tag);
    step(1'b1, w, lp, tag);
    for (int k = 1; k < gap; k++) step(1'b0, '0, lp, tag);
  endtask

  initial begin
    for (int i = 0; i < SCHED_N; i++) sched[i] = 1'b1;
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R6: reset state
    chk(line_a === 1'b1, "R6", line_a, 1'b1);
    chk(wrap_out === 1'b1, "R6", wrap_out, 1'b1);
    chk(err_align === 1'b0, "R6", err_align, 1'b0);
    rst = 1'b0;
    // R6: idle ones before the first word
    for (int k = 0; k < 5; k++) step(1'b0, '0, 1'b0, "R6");
    // R1 R2 R8: single word, then idle fill
    send(10'b00_0111_1100, 25, 1'b0, "R2");
    send(10'h3FF, 10, 1'b0, "R1");
    send(10'h000, 20, 1'b0, "R8");
    // R3: back-to-back words
    for (int n = 0; n < 8; n++) send(W'($urandom), 10, 1'b0, "R3");
    // R5 R9: loopback switched during a stream
    for (int n = 0; n < 6; n++) begin
      step(1'b1, W'($urandom), n[0], "R9");
      for (int k = 1; k < 10; k++) step(1'b0, '0, (k > 4) ^ n[0], "R9");
    end
    // R7: short and long spacings
    send(10'h155, 7, 1'b0, "R7");
    send(10'h2AA, 13, 1'b0, "R7");
    send(10'h0F0, 1, 1'b0, "R7");
    send(10'h30F, 10, 1'b0, "R7");
    send(10'h1C3, 20, 1'b1, "R5");
    // Random mix
    for (int n = 0; n < 70; n++) begin
      int gap;
      gap = (($urandom % 6) == 0) ? 1 + int'($urandom % 16) : 10;
      send(W'($urandom), gap, (($urandom % 4) == 0), "R2");
    end
    for (int k = 0; k < 15; k++) step(1'b0, '0, 1'b0, "R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule